// File: doc/BRIEF.md
# Bit-Serial Associative Add Sequencer

This block drives an associative array, a memory in which every row can compare and rewrite its own bits in parallel, so that the array adds two unsigned fields held side by side in each row. It has no adder of its own. Each addition becomes a stream of broadcast commands. A masked compare marks the rows whose selected columns equal a pattern. A masked write then rewrites the selected columns of the marked rows. The sequence walks the operands one bit position at a time, from the least significant bit upward, and keeps the running carry in a spare column of every row.

After a start strobe, the sequencer latches the three field offsets, the operand width and the carry-keep option. It issues one command per cycle and pulses a done flag once the sequence is over. Latency grows linearly with the width. Every row of the array is processed in the same cycles, so the row count does not change the latency.

Top module: `assoc_add_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, `cmd_valid`, `busy` and `done` are 0.
- R2: Command encoding is as follows. With `cmd_write`=0, a row becomes tagged exactly when `((row ^ cmd_data) & cmd_mask) == 0`. With `cmd_write`=1, every tagged row becomes `(row & ~cmd_mask) | (cmd_data & cmd_mask)`. Only write commands change rows.
- R3: After the sequence, the result field of every row (width W, starting at column `res_off`) holds `(a + b) mod 2^W`. Here `a` and `b` are the W-bit fields at `opa_off` and `opb_off`, and W is `width` clamped to 1..MAX_W.
- R4: A sequence issues exactly `2 + 10*W` commands when `keep_carry`=1, and `4 + 10*W` when `keep_carry`=0, one per cycle on consecutive cycles.
- R5: After the sequence, column CARRY_COL holds the carry out of bit W-1 when `keep_carry`=1, and holds 0 when `keep_carry`=0.
- R6: Write masks only touch the result field and the carry column, so every other column of every row is unchanged.
- R7: `done` is a one-cycle pulse in the cycle right after the last command. `busy` is high from the cycle after the start through the last command.
- R8: A `start` that arrives while `busy` is high is ignored and does not change the running sequence.
- R9: Each write command comes directly after a compare command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when idle |
| opa_off | input | OFF_W | Lowest column of operand a |
| opb_off | input | OFF_W | Lowest column of operand b |
| res_off | input | OFF_W | Lowest column of the result field |
| width | input | WID_W | Operand width in bits |
| keep_carry | input | 1 | Leave the final carry in the carry column |
| busy | output | 1 | Sequence in progress |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_write | output | 1 | 0 = masked compare, 1 = masked write |
| cmd_mask | output | ROW_W | Columns taking part in the command |
| cmd_data | output | ROW_W | Compare pattern or write value |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A wrong carry or a misordered pattern table does not show up on the command bus right away. It shows up only in the array contents, one bit position later, as a wrong result bit in some rows. For that reason the bench keeps its own model of a 256-row array and compares every result field after each sequence. A wrong bit counter or wrong state bookkeeping shows up at once at the ports, as a command count that differs from the formula or as a misplaced done pulse. Both are checked on every run.

// File: rtl/assoc_add_seq.sv
module assoc_add_seq #(
  parameter int ROW_W     = 32,
  parameter int MAX_W     = 16,
  parameter int CARRY_COL = ROW_W - 1,
  localparam int OFF_W    = $clog2(ROW_W),
  localparam int WID_W    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFF_W-1:0] opa_off,
  input  logic [OFF_W-1:0] opb_off,
  input  logic [OFF_W-1:0] res_off,
  input  logic [WID_W-1:0] width,
  input  logic             keep_carry,
  output logic             busy,
  output logic             cmd_valid,
  output logic             cmd_write,
  output logic [ROW_W-1:0] cmd_mask,
  output logic [ROW_W-1:0] cmd_data,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_CLR, S_BIT, S_FIN} state_t;

  state_t           st;
  logic [3:0]       step;
  logic [WID_W-1:0] bit_i, w_q;
  logic [OFF_W-1:0] a_q, b_q, r_q;
  logic             keep_q, last;
  logic [ROW_W-1:0] abit, bbit, rbit, cbit, rfield;
  logic [2:0]       pat;

  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  assign busy      = (st != S_IDLE);
  assign cmd_valid = busy;
  assign cmd_write = step[0];
  assign abit   = ONE << (int'(a_q) + int'(bit_i));
  assign bbit   = ONE << (int'(b_q) + int'(bit_i));
  assign rbit   = ONE << (int'(r_q) + int'(bit_i));
  assign cbit   = ONE << CARRY_COL;
  assign rfield = ~({ROW_W{1'b1}} << w_q) << r_q;
  assign last   = (st == S_BIT && step == 4'd9 && bit_i == w_q - 1'b1 && keep_q)
               || (st == S_FIN && step == 4'd1);

  // pattern order {a,b,c}: 001,010,100,111,110 - a rewritten row never meets a later one
  always_comb begin
    case (step[3:1])
      3'd0:    pat = 3'b001;
      3'd1:    pat = 3'b010;
      3'd2:    pat = 3'b100;
      3'd3:    pat = 3'b111;
      default: pat = 3'b110;
    endcase
  end

  always_comb begin
    cmd_mask = '0;
    cmd_data = '0;
    case (st)
      S_CLR: if (cmd_write) cmd_mask = rfield | cbit;
      S_FIN: if (cmd_write) cmd_mask = cbit;
      S_BIT: begin
        if (!cmd_write) begin
          cmd_mask = abit | bbit | cbit;
          cmd_data = (pat[2] ? abit : '0) | (pat[1] ? bbit : '0) | (pat[0] ? cbit : '0);
        end else if (pat == 3'b001) begin
          cmd_mask = rbit | cbit;
          cmd_data = rbit;
        end else if (pat == 3'b110) begin
          cmd_mask = cbit;
          cmd_data = cbit;
        end else begin
          cmd_mask = rbit;
          cmd_data = rbit;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      bit_i  <= '0;
      w_q    <= WID_W'(1);
      a_q    <= '0;
      b_q    <= '0;
      r_q    <= '0;
      keep_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_CLR;
          step   <= '0;
          bit_i  <= '0;
          a_q    <= opa_off;
          b_q    <= opb_off;
          r_q    <= res_off;
          keep_q <= keep_carry;
          w_q    <= (width == '0) ? WID_W'(1)
                  : (int'(width) > MAX_W) ? WID_W'(MAX_W) : width;
        end
        S_CLR: begin
          step <= step + 1'b1;
          if (step == 4'd1) begin
            st   <= S_BIT;
            step <= '0;
          end
        end
        S_BIT: begin
          step <= step + 1'b1;
          if (step == 4'd9) begin
            step <= '0;
            if (bit_i == w_q - 1'b1) st <= keep_q ? S_IDLE : S_FIN;
            else bit_i <= bit_i + 1'b1;
          end
        end
        S_FIN: begin
          step <= step + 1'b1;
          if (step == 4'd1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_write_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> $past(cmd_valid && !cmd_write));
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && $past(cmd_valid)));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_valid) |-> done);
  a_r6_write_confined: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> ((cmd_mask & ~(rfield | cbit)) == '0));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(w_q) && $stable(r_q));
endmodule

// File: tb/tb_assoc_add_seq.sv
`timescale 1ns/1ps
module tb_assoc_add_seq;
  localparam int ROW_W = 32, MAX_W = 16, CC = 31, NR = 256;
  localparam int OFF_W = $clog2(ROW_W), WID_W = $clog2(MAX_W + 1);

  logic clk = 0, rst_n = 0, start = 0, keep_carry = 0;
  logic [OFF_W-1:0] opa_off = 0, opb_off = 0, res_off = 0;
  logic [WID_W-1:0] width = 0;
  logic busy, cmd_valid, cmd_write, done;
  logic [ROW_W-1:0] cmd_mask, cmd_data;

  int total = 0, bad = 0;
  logic [31:0] arr  [NR];
  logic [31:0] init [NR];
  bit          tag  [NR];

  always #2 clk = ~clk;

  assoc_add_seq #(.ROW_W(ROW_W), .MAX_W(MAX_W), .CARRY_COL(CC)) dut (
    .clk, .rst_n, .start, .opa_off, .opb_off, .res_off, .width, .keep_carry,
    .busy, .cmd_valid, .cmd_write, .cmd_mask, .cmd_data, .done);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int w, input int ao, input int bo, input int ro,
                     input bit keep, input bit poke);
    int ncmd = 0, nwr = 0, ncmp = 0, cyc = 0, orphan = 0;
    bit prev_cmp = 0, seen = 0, ok3 = 1, ok5 = 1, ok6 = 1;
    longint m = (64'd1 << w) - 1;
    longint a3 = 0, e3 = 0;
    for (int r = 0; r < NR; r++) begin
      longint a, b;
      logic [31:0] v;
      a = (w <= 4) ? (r & m) : ((r * 73 + 11) & m);
      b = (w <= 4) ? ((r >> 4) & m) : (((r * 151 + 7) ^ (r >> 3)) & m);
      v = 32'(r * 32'h9E3779B1 + 32'h5A5A);
      v = (v & ~(32'(m) << ao)) | (32'(a) << ao);
      v = (v & ~(32'(m) << bo)) | (32'(b) << bo);
      arr[r] = v;
      init[r] = v;
      tag[r] = 0;
    end
    @(negedge clk);
    opa_off = OFF_W'(ao); opb_off = OFF_W'(bo); res_off = OFF_W'(ro);
    width = WID_W'(w); keep_carry = keep; start = 1;
    @(negedge clk);
    start = 0;
    while (!seen && cyc < 1000) begin
      cyc++;
      if (poke && cyc == 5) begin
        width = WID_W'(1); res_off = 0; start = 1;   // R8: must be ignored
      end else start = 0;
      if (done) begin
        seen = 1;
        chk(cmd_valid == 0 && prev_cmp == 0 || cmd_valid == 0, "R7 done after last", cmd_valid, 0);
      end else if (cmd_valid) begin
        ncmd++;
        // R2 array model
        if (!cmd_write) begin
          for (int r = 0; r < NR; r++) tag[r] = ((arr[r] ^ cmd_data) & cmd_mask) == 0;
          ncmp++;
          prev_cmp = 1;
        end else begin
          for (int r = 0; r < NR; r++)
            if (tag[r]) arr[r] = (arr[r] & ~cmd_mask) | (cmd_data & cmd_mask);
          nwr++;
          if (!prev_cmp) orphan++;
          prev_cmp = 0;
        end
      end else if (ncmd > 0) begin
        chk(0, "R4 gap in command stream", ncmd, 0);
      end
      @(negedge clk);
    end
    start = 0;
    chk(seen, "R7 done seen (watchdog)", seen, 1);
    chk(done == 0, "R7 done is one cycle", done, 0);
    chk(busy == 0, "R7 busy low after done", busy, 0);
    chk(ncmd == (keep ? 2 + 10 * w : 4 + 10 * w), "R4 command count", ncmd, keep ? 2 + 10 * w : 4 + 10 * w);
    chk(orphan == 0 && nwr == ncmp, "R9 write follows compare", orphan, 0);
    for (int r = 0; r < NR; r++) begin
      longint a, b, s, got;
      logic [31:0] keepm;
      a = (init[r] >> ao) & m;
      b = (init[r] >> bo) & m;
      s = a + b;
      got = (arr[r] >> ro) & m;
      if (ok3 && got != (s & m)) begin ok3 = 0; a3 = got; e3 = s & m; end
      if (arr[r][CC] != (keep ? s[w] : 1'b0)) ok5 = 0;
      keepm = ~((32'(m) << ro) | (32'd1 << CC));
      if ((arr[r] & keepm) != (init[r] & keepm)) ok6 = 0;
    end
    chk(ok3, $sformatf("R2/R3 sum field w=%0d", w), a3, e3);
    chk(ok5, $sformatf("R5 carry column w=%0d keep=%0d", w, keep), ok5, 1);
    chk(ok6, $sformatf("R6 other columns w=%0d", w), ok6, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && busy == 0 && done == 0, "R1 reset idle", {cmd_valid, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_valid == 0 && busy == 0 && done == 0, "R1 idle after reset", {cmd_valid, busy, done}, 0);
    for (int w = 1; w <= 10; w++) run(w, 0, 10, 20, w[0], 0);
    for (int w = 1; w <= 9; w++)  run(w, 21, 0, 11, !w[0], 0);
    run(6, 0, 10, 20, 1, 1);
    run(8, 21, 0, 11, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule